// File: doc/BRIEF.md
# SPI Quad Low-Side Switch Controller

This block is the serial control front end of a four-channel low-side switch. A host selects it with an active-low chip select and clocks in one 8-bit command frame in SPI mode 0. During the same frame the block returns a status byte. The status byte holds a 2-bit fault code for every channel. When the frame closes, the command drives the four channel-enable outputs and the fault memory is cleared.

Current limiting and temperature sensing happen outside the block. They arrive as two fault flags per channel, one for overload and one for overtemperature, and are synchronous to the system clock. A fault flag latches until the next chip-select rising edge, so a short event is still reported in the frame that follows. The SPI pins are asynchronous to the system clock. They are synchronized first, and every edge action is then taken in the system clock domain.

Top module: `spi_quad_switch`

## Requirements
- R1: After reset all channel enables are 0 and the serial output enable `sdo_oe` is 0.
- R2: While chip select is high, `sdo_oe` is 0, and clock or data activity on `sclk`/`sdi` leaves the channel enables unchanged.
- R3: After chip select falls, `sdo_oe` is 1 and `sdo` shows bit 7 of the status snapshot that was captured at that edge.
- R4: The status byte is sent MSB first and a new bit appears after each falling `sclk` edge. Bits [7:6], [5:4], [3:2] and [1:0] carry channels 4, 3, 2 and 1.
- R5: Each channel's 2-bit status code is {not overtemperature, not overload}: 11 means no fault, 10 means overload, 01 means overtemperature, and 00 means both.
- R6: A fault flag that was asserted at any time since the last chip-select rising edge is reported, even if the flag has been deasserted by the time chip select falls. A flag that is still asserted when the clear happens stays latched.
- R7: Command bits are sampled on rising `sclk` edges, MSB first. Channel k (1..4) takes its on/off command from bit 2(k-1), where 1 means on. Bit 2k-1 of each pair is reserved and ignored.
- R8: When chip select rises after exactly 8 rising `sclk` edges, the channel enables take the new command.
- R9: When chip select rises after any other number of rising `sclk` edges (fewer or more than 8), the channel enables keep their previous value.
- R10: Every chip-select rising edge clears the latched faults, including the rising edge of an aborted frame. After a rising edge `sdo_oe` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, idle low (asynchronous) |
| sdi | input | 1 | Serial command data in |
| ovl_flt | input | NUM_CH | Per-channel overload / current-limit flag |
| ot_flt | input | NUM_CH | Per-channel overtemperature flag |
| sdo | output | 1 | Serial status data out (valid when sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| chan_en | output | NUM_CH | Channel enable outputs |

## Verification
The bench builds the block with NUM_CH = 4 and SYNC_STAGES = 2. This gives an 8-bit frame and brings all sixteen command patterns and every fault-code combination within reach. Frames of 0 to 11 clock edges are generated, which exercises short frames, long frames and the saturating edge counter. Fault pulses are placed between frames, and one fault is held across a chip-select rising edge. Together these separate the sticky-latch behaviour from the clear-on-rise behaviour.

// File: rtl/spi_qs_pkg.sv
package spi_qs_pkg;

    typedef logic [1:0] diag_code_t;

    localparam diag_code_t CODE_OK   = 2'b11;
    localparam diag_code_t CODE_OVL  = 2'b10;
    localparam diag_code_t CODE_OT   = 2'b01;
    localparam diag_code_t CODE_BOTH = 2'b00;

    // Per-channel status code: upper bit clear on overtemperature,
    // lower bit clear on overload.
    function automatic diag_code_t encode_diag(input logic ovl, input logic ot);
        return {~ot, ~ovl};
    endfunction

endpackage

// File: rtl/spi_qs_sync.sv
module spi_qs_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q.chain[s] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/spi_qs_diag.sv
module spi_qs_diag
    import spi_qs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ovl_flt,
    input  logic [NUM_CH-1:0]     ot_flt,
    input  logic                  clear,
    output logic [2*NUM_CH-1:0]   code_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] ovl;
        logic [NUM_CH-1:0] ot;
    } diag_state_t;

    diag_state_t st_d, st_q;

    // A flag still active when the clear arrives wins over the clear.
    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.ovl = ovl_flt;
            st_d.ot  = ot_flt;
        end else begin
            st_d.ovl = st_q.ovl | ovl_flt;
            st_d.ot  = st_q.ot  | ot_flt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The snapshot also includes flags that are active in this cycle.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_code
        assign code_o[2*k+1:2*k] = encode_diag(st_q.ovl[k] | ovl_flt[k],
                                               st_q.ot[k]  | ot_flt[k]);
    end

endmodule

// File: rtl/spi_quad_switch.sv
module spi_quad_switch
    import spi_qs_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [NUM_CH-1:0] ovl_flt,
    input  logic [NUM_CH-1:0] ot_flt,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [NUM_CH-1:0] chan_en
);

    localparam int FRAME_BITS = 2 * NUM_CH;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] tx;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_CH-1:0]     en;
        logic                  oe;
        logic                  cs_prev;
        logic                  sclk_prev;
    } qs_state_t;

    qs_state_t st_d, st_q;

    logic [2:0]            pins_sync;
    logic                  cs_lvl, sclk_lvl, sdi_lvl;
    logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [2*NUM_CH-1:0]   diag_code;

    // Bit order: {cs_n, sclk, sdi}; chip select idles high.
    spi_qs_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdi}),
        .sync_o  (pins_sync)
    );

    assign cs_lvl   = pins_sync[2];
    assign sclk_lvl = pins_sync[1];
    assign sdi_lvl  = pins_sync[0];

    assign cs_fall   =  st_q.cs_prev & ~cs_lvl;
    assign cs_rise   = ~st_q.cs_prev &  cs_lvl;
    assign sclk_rise = ~st_q.sclk_prev &  sclk_lvl & ~cs_lvl;
    assign sclk_fall =  st_q.sclk_prev & ~sclk_lvl & ~cs_lvl;

    spi_qs_diag #(
        .NUM_CH (NUM_CH)
    ) u_diag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovl_flt (ovl_flt),
        .ot_flt  (ot_flt),
        .clear   (cs_rise),
        .code_o  (diag_code)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_lvl;
        st_d.sclk_prev = sclk_lvl;

        if (cs_fall) begin
            st_d.tx  = diag_code;
            st_d.rx  = '0;
            st_d.cnt = '0;
            st_d.oe  = 1'b1;
        end else if (cs_rise) begin
            st_d.oe = 1'b0;
            if (st_q.cnt == CNT_W'(FRAME_BITS)) begin
                for (int k = 0; k < NUM_CH; k++) begin
                    st_d.en[k] = st_q.rx[2*k];
                end
            end
        end else begin
            if (sclk_rise) begin
                st_d.rx = {st_q.rx[FRAME_BITS-2:0], sdi_lvl};
                if (st_q.cnt != CNT_W'(CNT_MAX)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (sclk_fall) begin
                st_d.tx = {st_q.tx[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo     = st_q.tx[FRAME_BITS-1];
    assign sdo_oe  = st_q.oe;
    assign chan_en = st_q.en;

endmodule

// File: rtl/spi_quad_switch_checker.sv
module spi_quad_switch_checker #(
    parameter int NUM_CH     = 4,
    parameter int FRAME_BITS = 8,
    parameter int CNT_W      = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_fall,
    input logic                cs_rise,
    input logic [CNT_W-1:0]    cnt_q,
    input logic [NUM_CH-1:0]   ovl_flt,
    input logic [NUM_CH-1:0]   ot_flt,
    input logic [2*NUM_CH-1:0] diag_code,
    input logic                sdo_oe,
    input logic [NUM_CH-1:0]   chan_en
);

    assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> sdo_oe);

    assert_oe_off_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe);

    assert_en_only_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(cs_rise));

    assert_en_needs_full_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> ($past(cnt_q) == CNT_W'(FRAME_BITS)));

    assert_ovl_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_flt[0] |=> !diag_code[0]);

    assert_ot_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flt[0] |=> !diag_code[1]);

    assert_clear_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && (ovl_flt == '0) && (ot_flt == '0))
        |=> ((ovl_flt != '0) || (ot_flt != '0) || (diag_code == '1)));

endmodule

bind spi_quad_switch spi_quad_switch_checker #(
    .NUM_CH     (NUM_CH),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .cnt_q     (st_q.cnt),
    .ovl_flt   (ovl_flt),
    .ot_flt    (ot_flt),
    .diag_code (diag_code),
    .sdo_oe    (sdo_oe),
    .chan_en   (chan_en)
);

// File: tb/spi_quad_switch_bench.sv
`timescale 1ns/1ps
module spi_quad_switch_bench;

    localparam int NCH  = 4;
    localparam int HALF = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b0;
    logic           sdi = 1'b0;
    logic [NCH-1:0] ovl_flt = '0;
    logic [NCH-1:0] ot_flt = '0;
    logic           sdo;
    logic           sdo_oe;
    logic [NCH-1:0] chan_en;

    int checks = 0;
    int errors = 0;

    logic [NCH-1:0] m_ovl = '0;
    logic [NCH-1:0] m_ot  = '0;
    logic [NCH-1:0] m_en  = '0;
    logic [7:0]     got_status;

    always #4 clk = ~clk;

    spi_quad_switch #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_spi_quad_switch (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ovl_flt(ovl_flt), .ot_flt(ot_flt),
        .sdo(sdo), .sdo_oe(sdo_oe), .chan_en(chan_en)
    );

    function automatic logic [7:0] exp_status(input logic [3:0] ovl, input logic [3:0] ot);
        logic [7:0] s;
        for (int k = 0; k < 4; k++) begin
            s[2*k+1] = ~ot[k];
            s[2*k]   = ~ovl[k];
        end
        return s;
    endfunction

    function automatic logic [3:0] exp_enable(input logic [7:0] cmd);
        logic [3:0] e;
        for (int k = 0; k < 4; k++) e[k] = cmd[2*k];
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_faults(input logic [3:0] ovl, input logic [3:0] ot);
        ovl_flt = ovl; ot_flt = ot;
        wait_clk(3);
        m_ovl |= ovl; m_ot |= ot;
        ovl_flt = '0; ot_flt = '0;
        wait_clk(2);
    endtask

    // Runs one frame with nbits rising edges; checks R3, R4/R5, R8/R9, R10.
    task automatic run_frame(input logic [7:0] cmd, input int nbits);
        logic [7:0] es;
        es = exp_status(m_ovl, m_ot);
        cs_n = 1'b0;
        wait_clk(HALF);
        check("R3 oe after cs fall", {31'd0, sdo_oe}, 32'd1);
        check("R3 first status bit", {31'd0, sdo}, {31'd0, es[7]});
        got_status = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? cmd[7-i] : 1'($urandom_range(0, 1));
            wait_clk(HALF);
            if (i < 8) got_status[7-i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        if (nbits >= 8) check("R4 R5 status byte", {24'd0, got_status}, {24'd0, es});
        cs_n = 1'b1;
        m_ovl = ovl_flt; m_ot = ot_flt;
        wait_clk(8);
        if (nbits == 8) begin
            m_en = exp_enable(cmd);
            check("R7 R8 enables after full frame", {28'd0, chan_en}, {28'd0, m_en});
        end else begin
            check("R9 enables kept after odd frame", {28'd0, chan_en}, {28'd0, m_en});
        end
        check("R10 oe off after cs rise", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        wait_clk(4);
        check("R1 enables at reset", {28'd0, chan_en}, 32'd0);
        check("R1 oe at reset", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1;
        wait_clk(6);
        check("R1 enables after reset", {28'd0, chan_en}, 32'd0);

        // R7: all channels on, reserved bits zero; then reserved bits only.
        run_frame(8'b0101_0101, 8);
        run_frame(8'b1010_1010, 8);
        run_frame(8'b0001_0100, 8);

        // R2: activity with chip select high is ignored.
        for (int i = 0; i < 10; i++) begin
            sdi = 1'($urandom_range(0, 1));
            sclk = 1'b1; wait_clk(HALF);
            check("R2 oe low while deselected", {31'd0, sdo_oe}, 32'd0);
            sclk = 1'b0; wait_clk(HALF);
        end
        check("R2 enables unchanged", {28'd0, chan_en}, {28'd0, m_en});

        // R5: every code on distinct channels.
        pulse_faults(4'b1010, 4'b1100);
        run_frame(8'b0100_0001, 8);
        // R6: fault held across the clearing edge stays latched.
        ovl_flt = 4'b0010;
        wait_clk(3);
        m_ovl |= ovl_flt;
        run_frame(8'b0000_0000, 8);
        ovl_flt = '0;
        wait_clk(3);
        run_frame(8'b0101_0000, 8);
        // R10: an aborted frame still clears faults.
        pulse_faults(4'b0001, 4'b1000);
        run_frame(8'hFF, 3);
        run_frame(8'h11, 8);
        // R9: long frame is discarded.
        run_frame(8'h44, 11);
        run_frame(8'h00, 0);

        for (int n = 0; n < 40; n++) begin
            logic [7:0] cmd;
            int nb;
            cmd = 8'($urandom);
            nb  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 11)) : 8;
            if ($urandom_range(0, 1) == 1)
                pulse_faults(4'($urandom), 4'($urandom));
            run_frame(cmd, nb);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule